// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A baud tick enable comes in at 16 or 8 times the bit rate, and the `hse` input picks between the two rates. While idle, the receiver waits for a tick on which the line is low. It confirms the start bit at mid-bit. After that it samples each data bit, the optional parity bit and the stop bit once per bit period. The character length runs from 5 to 8 bits, and data arrive least significant bit first.

Each finished character is written into a one-entry holding register, together with its parity, framing and break flags. The holding register feeds a receive FIFO through a valid/ready handshake. Configuration is captured when the start bit is detected. Changing the inputs in the middle of a character therefore has no effect on that character.

Top module: `uart_rx_engine`

## Requirements
- R1: While idle, the first baud tick that sees `rxd` low starts a reception. The start bit is accepted only if `rxd` is still low on the 8th tick after that tick when `hse`=0, or on the 4th tick when `hse`=1.
- R2: If `rxd` is high at that validation tick, the receiver returns to idle and produces no word. For example, a low pulse lasting exactly 8 ticks (16x mode) or 4 ticks (8x mode) is rejected.
- R3: After a valid start, each following bit is sampled 16 ticks (`hse`=0) or 8 ticks (`hse`=1) after the previous sample.
- R4: `char_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. The first data bit received lands in `out_data[0]`, and unused upper bits read 0.
- R5: When `par_en`=1, a parity bit follows the data. The expected value depends on `par_mode`: 0 gives even parity (the parity bit equals the XOR of the data), 1 gives odd parity, 2 forces 1 and 3 forces 0. A mismatch sets `out_perr`. When `par_en`=0, no parity bit is sampled and `out_perr` is 0.
- R6: A high stop sample is valid. A low stop sample sets `out_ferr`.
- R7: `out_berr` is set, together with `out_ferr`, when every data, parity and stop sample was low.
- R8: `out_valid` is 0 after reset. Once set, `out_valid` and the word fields hold steady until a cycle with `out_ready` high accepts them.
- R9: `hse`, `char_len`, `par_en` and `par_mode` are captured at start detection. Changing them during a character does not alter how that character is received.
- R10: A word that completes while the holding register is full and not being read in the same cycle is discarded. The held word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick enable |
| hse | input | 1 | 1 = 8x oversampling, 0 = 16x |
| rxd | input | 1 | Serial input, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | 0 even, 1 odd, 2 forced one, 3 forced zero |
| out_valid | output | 1 | Holding register full |
| out_ready | input | 1 | Sink accepts the held word |
| out_data | output | 8 | Received character, right-aligned |
| out_perr | output | 1 | Parity error |
| out_ferr | output | 1 | Framing error |
| out_berr | output | 1 | Break detected |

## Verification
A tick counter that is off by one, or that uses the wrong mode's spacing, shifts the sample points toward the bit edges. Frames driven with exact bit periods then return corrupted bits on the next completed word. A bit counter stuck at the wrong length shows up as a shifted character or a missing word. A wrong parity or error-flag decode shows up at the very next handshake as a wrong `out_perr`, `out_ferr` or `out_berr`. A phase register that misses the glitch return either emits a spurious word or swallows the next real frame, and the scoreboard catches either case by its queue count.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int RX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [RX_BITS-1:0] data;
    logic               perr;
    logic               ferr;
    logic               berr;
  } rx_word_t;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OVS_SLOW = 16,
  parameter int OVS_FAST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic fast,
  input  logic half,
  output logic strobe
);
  localparam int CW = $clog2(OVS_SLOW);
  localparam logic [CW-1:0] LIM_SLOW_FULL = CW'(OVS_SLOW - 1);
  localparam logic [CW-1:0] LIM_SLOW_HALF = CW'(OVS_SLOW / 2 - 1);
  localparam logic [CW-1:0] LIM_FAST_FULL = CW'(OVS_FAST - 1);
  localparam logic [CW-1:0] LIM_FAST_HALF = CW'(OVS_FAST / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    if (fast) limit = half ? LIM_FAST_HALF : LIM_FAST_FULL;
    else      limit = half ? LIM_SLOW_HALF : LIM_SLOW_FULL;
  end

  assign strobe = tick && !clear && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)       cnt_d = '0;
    else if (strobe) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter #(
  parameter int NBITS = 8,
  parameter int LW    = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [LW-1:0]    len,
  output logic [NBITS-1:0] data,
  output logic             par
);
  logic [NBITS-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)          sr_d = '0;
    else if (shift_en) sr_d = {bit_in, sr_q[NBITS-1:1]};
  end

  assign data = sr_q >> (LW'(NBITS) - len);
  assign par  = ^data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/uart_rx_outreg.sv
module uart_rx_outreg
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  rx_word_t wr_word,
  input  logic     rd_ready,
  output logic     rd_valid,
  output rx_word_t rd_word
);
  logic     valid_d, accept;
  rx_word_t word_d;

  assign accept = wr_en && (!rd_valid || rd_ready);

  always_comb begin
    valid_d = rd_valid;
    word_d  = rd_word;
    if (accept) begin
      valid_d = 1'b1;
      word_d  = wr_word;
    end else if (rd_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_word  <= word_d;
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OVS_SLOW = 16,
  parameter int OVS_FAST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               hse,
  input  logic               rxd,
  input  logic [1:0]         char_len,
  input  logic               par_en,
  input  logic [1:0]         par_mode,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RX_BITS-1:0] out_data,
  output logic               out_perr,
  output logic               out_ferr,
  output logic               out_berr
);
  localparam int LW = $clog2(RX_BITS + 1);
  localparam logic [LW-1:0] MIN_LEN = LW'(RX_BITS - 3);

  logic [1:0]   rst_sync_q;
  logic         rst_ni;
  rx_state_e    state_q, state_d;
  logic         hse_q, hse_d, pen_q, pen_d, par_q, par_d, any_q, any_d;
  logic [1:0]   pmode_q, pmode_d;
  logic [LW-1:0] len_q, len_d, bitcnt_q, bitcnt_d;
  logic         samp_stb, start_det, shift_en, wr_en, sh_par, exp_par;
  logic [RX_BITS-1:0] sh_data;
  rx_word_t     wr_word, rd_word;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign start_det = (state_q == ST_IDLE) && baud_tick && !rxd;

  uart_rx_sampler #(.OVS_SLOW(OVS_SLOW), .OVS_FAST(OVS_FAST)) u_sampler (
    .clk(clk), .rst_n(rst_ni), .tick(baud_tick),
    .clear(state_q == ST_IDLE), .fast(hse_q),
    .half(state_q == ST_START), .strobe(samp_stb)
  );

  uart_rx_shifter #(.NBITS(RX_BITS), .LW(LW)) u_shifter (
    .clk(clk), .rst_n(rst_ni), .load(start_det), .shift_en(shift_en),
    .bit_in(rxd), .len(len_q), .data(sh_data), .par(sh_par)
  );

  always_comb begin
    state_d  = state_q;
    hse_d    = hse_q;
    len_d    = len_q;
    pen_d    = pen_q;
    pmode_d  = pmode_q;
    bitcnt_d = bitcnt_q;
    par_d    = par_q;
    any_d    = any_q;
    shift_en = 1'b0;
    wr_en    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_det) begin
        state_d = ST_START;
        hse_d   = hse;
        len_d   = MIN_LEN + LW'(char_len);
        pen_d   = par_en;
        pmode_d = par_mode;
      end
      ST_START: if (samp_stb) begin
        if (rxd) state_d = ST_IDLE;
        else begin
          state_d  = ST_DATA;
          bitcnt_d = '0;
          any_d    = 1'b0;
          par_d    = 1'b0;
        end
      end
      ST_DATA: if (samp_stb) begin
        shift_en = 1'b1;
        any_d    = any_q | rxd;
        bitcnt_d = bitcnt_q + 1'b1;
        if (bitcnt_q == len_q - 1'b1) state_d = pen_q ? ST_PAR : ST_STOP;
      end
      ST_PAR: if (samp_stb) begin
        par_d   = rxd;
        any_d   = any_q | rxd;
        state_d = ST_STOP;
      end
      ST_STOP: if (samp_stb) begin
        wr_en   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (pmode_q)
      2'd0:    exp_par = sh_par;
      2'd1:    exp_par = ~sh_par;
      2'd2:    exp_par = 1'b1;
      default: exp_par = 1'b0;
    endcase
    wr_word.data = sh_data;
    wr_word.perr = pen_q && (par_q != exp_par);
    wr_word.ferr = !rxd;
    wr_word.berr = !rxd && !any_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hse_q    <= 1'b0;
      len_q    <= '0;
      pen_q    <= 1'b0;
      pmode_q  <= 2'd0;
      bitcnt_q <= '0;
      par_q    <= 1'b0;
      any_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      hse_q    <= hse_d;
      len_q    <= len_d;
      pen_q    <= pen_d;
      pmode_q  <= pmode_d;
      bitcnt_q <= bitcnt_d;
      par_q    <= par_d;
      any_q    <= any_d;
    end
  end

  uart_rx_outreg u_outreg (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_word(wr_word),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_word(rd_word)
  );

  assign out_data = rd_word.data;
  assign out_perr = rd_word.perr;
  assign out_ferr = rd_word.ferr;
  assign out_berr = rd_word.berr;
endmodule

// File: rtl/uart_rx_engine_chk.sv
module uart_rx_engine_chk
  import uart_rx_pkg::*;
(
  input logic               clk,
  input logic               rst_ni,
  input logic               baud_tick,
  input logic               rxd,
  input logic               out_valid,
  input logic               out_ready,
  input logic [RX_BITS-1:0] out_data,
  input logic               out_perr,
  input logic               out_ferr,
  input logic               out_berr,
  input rx_state_e          state_q,
  input logic               samp_stb,
  input logic               hse_q,
  input logic [3:0]         len_q
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && baud_tick && !rxd) |=> (state_q == ST_START));

  assert_glitch_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_START && samp_stb && rxd) |=> (state_q == ST_IDLE));

  assert_break_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_berr) |-> (out_ferr && out_data == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable({out_perr, out_ferr, out_berr})));

  assert_cfg_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
      |-> ($stable(hse_q) && $stable(len_q)));
endmodule

bind uart_rx_engine uart_rx_engine_chk u_chk (.*);

// File: tb/uart_rx_engine_test.sv
module uart_rx_engine_test;
  logic clk = 1'b0;
  logic rst_n, baud_tick, hse, rxd, par_en, out_ready;
  logic [1:0] char_len, par_mode;
  logic out_valid, out_perr, out_ferr, out_berr;
  logic [7:0] out_data;

  int checks = 0;
  int errs   = 0;
  logic [10:0] exp_q[$];

  always #10 clk = ~clk;

  uart_rx_engine uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .hse(hse), .rxd(rxd),
    .char_len(char_len), .par_en(par_en), .par_mode(par_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_berr(out_berr)
  );

  // monitor: samples mid low phase, the handshake happens on the next rising edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n && out_valid && out_ready) begin
      logic [10:0] got;
      got = {out_data, out_perr, out_ferr, out_berr};
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R2 R10 unexpected word: actual %h expected none", got);
      end else begin
        logic [10:0] exp;
        exp = exp_q.pop_front();
        if (got !== exp) begin
          errs++;
          $display("FAIL R3 R4 R5 R6 R7 word: actual %h expected %h", got, exp);
        end
      end
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // drives one frame; pushes the expected word when keep is set
  task automatic frame(input logic [7:0] d, input int nbits, input bit fast,
                       input bit pe, input logic [1:0] pm, input bit bad_par,
                       input bit stop, input bit flip, input bit keep);
    int os;
    logic [7:0] m;
    logic pbit, perr, berr;
    os = fast ? 8 : 16;
    m  = d & 8'((1 << nbits) - 1);
    case (pm)
      2'd0: pbit = ^m;
      2'd1: pbit = ~^m;
      2'd2: pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    pbit = pbit ^ bad_par;
    perr = pe && bad_par;
    berr = !stop && (m == 0) && (!pe || !pbit);
    if (keep) exp_q.push_back({m, perr, !stop, berr});
    @(negedge clk);
    hse = fast; char_len = 2'(nbits - 5); par_en = pe; par_mode = pm;
    rxd = 1'b0;
    ticks(os);
    if (flip) begin
      hse = ~fast; char_len = ~char_len; par_en = ~pe; par_mode = ~pm;
    end
    for (int i = 0; i < nbits; i++) begin
      rxd = m[i];
      ticks(os);
    end
    if (pe) begin
      rxd = pbit;
      ticks(os);
    end
    rxd = stop;
    ticks(os);
    rxd = 1'b1;
    ticks(2 * os);
  endtask

  initial begin
    #(20 * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; baud_tick = 1'b0; hse = 1'b0; rxd = 1'b1;
    char_len = 2'd3; par_en = 1'b0; par_mode = 2'd0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8 valid after release", 32'(out_valid), 0);

    frame(8'hA5, 8, 0, 0, 2'd0, 0, 1, 0, 1);  // R1 R3 R4 16x
    frame(8'h3C, 8, 1, 0, 2'd0, 0, 1, 0, 1);  // R1 R3 8x
    frame(8'h15, 5, 0, 1, 2'd0, 0, 1, 0, 1);  // R4 R5 even
    frame(8'h2B, 6, 1, 1, 2'd1, 0, 1, 0, 1);  // R4 R5 odd
    frame(8'hDA, 7, 0, 1, 2'd2, 0, 1, 0, 1);  // R4 R5 forced one
    frame(8'h81, 8, 0, 1, 2'd3, 1, 1, 0, 1);  // R5 forced zero mismatch
    frame(8'h66, 8, 1, 1, 2'd0, 1, 1, 0, 1);  // R5 even mismatch
    frame(8'h55, 8, 0, 0, 2'd0, 0, 0, 0, 1);  // R6 framing error
    frame(8'h00, 8, 0, 0, 2'd0, 0, 0, 0, 1);  // R7 break
    frame(8'h00, 7, 1, 1, 2'd0, 0, 0, 0, 1);  // R7 break with parity
    frame(8'hC3, 8, 0, 1, 2'd1, 0, 1, 1, 1);  // R9 config changed mid frame
    frame(8'h09, 5, 1, 0, 2'd0, 0, 1, 1, 1);  // R9 from 8x

    // R2 glitches at the boundary: low exactly up to the validation tick
    @(negedge clk); hse = 1'b0; rxd = 1'b0; ticks(8); rxd = 1'b1; ticks(40);
    @(negedge clk); hse = 1'b1; rxd = 1'b0; ticks(4); rxd = 1'b1; ticks(20);
    check(out_valid == 1'b0, "R2 glitch produced word", 32'(out_valid), 0);

    // R8 and R10: hold with the sink stalled, second word dropped
    out_ready = 1'b0;
    frame(8'h4E, 8, 1, 0, 2'd0, 0, 1, 0, 1);
    check(out_valid == 1'b1, "R8 valid held", 32'(out_valid), 1);
    check(out_data == 8'h4E, "R8 data held", 32'(out_data), 32'h4E);
    frame(8'hB1, 8, 1, 0, 2'd0, 0, 1, 0, 0);
    check(out_valid == 1'b1, "R10 valid kept", 32'(out_valid), 1);
    check(out_data == 8'h4E, "R10 held word kept", 32'(out_data), 32'h4E);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8 released after accept", 32'(out_valid), 0);

    frame(8'h7E, 8, 0, 0, 2'd0, 0, 1, 0, 1);  // recovery after drop, R10
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R3 words outstanding", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule